// File: doc/BRIEF.md
# I2C SCL Timing Count Calculator

This block turns a requested I2C bus speed and the frequency of the controller's clock into the three counts an I2C controller needs: how many clock cycles SCL stays high, how many it stays low, and how many cycles SDA is held after SCL falls. It picks the speed class (standard, fast or high-speed) from the requested rate. It converts the class's minimum high and low times, the edge rise and fall times, and the SDA hold time into cycle counts. It then works back from the controller's fixed overhead cycles to the programmable counts.

The minimum high and low time of each class are parameters. The caller may override the rise, fall and hold times in nanoseconds, where zero keeps the built-in value. When the counts do not fill a whole SCL period, the block spreads the shortfall evenly over the two counts and gives any odd cycle to the low count. If the overheads leave no room, the block reports an error instead of counts.

All divisions share one iterative divider. A calculation therefore takes a fixed, bounded number of cycles and ends with a single done pulse. A start request that arrives while a calculation is in flight is ignored.

Top module: `i2c_scl_timing_calc`

## Requirements
- R1: After reset, busy_o, done_o and err_o are 0 and hcnt_o, lcnt_o and sda_hold_o are 0.
- R2: The class is high-speed (code 2) when hs_allow_i is 1 and req_speed_i is at or above the high-speed rate (default 3,400,000). Otherwise it is fast (code 1) when req_speed_i is at or above the fast rate (default 400,000), and standard (code 0) below that. The class sets the period divisor (100 k, 400 k or 3.4 M) and the default times.
- R3: A time of T ns becomes ceil(floor(clk_hz/1000) * T / 1,000,000) cycles. The default rise/fall times are 1000/300 ns (standard), 300/300 ns (fast) and 120/120 ns (high-speed). A nonzero rise_ns_i or fall_ns_i replaces the default.
- R4: sda_hold_o is the count for 300 ns, or for hold_ns_i when that input is nonzero.
- R5: Before padding, hcnt = high_cnt - fall_cnt - 7 - spk and lcnt = low_cnt - rise_cnt + fall_cnt - 1, where spk is spk_len_i.
- R6: If either unpadded count is negative, err_o is 1 with the done pulse, and hcnt_o, lcnt_o and sda_hold_o are all 0.
- R7: Let total = hcnt + lcnt + 8 + spk + rise_cnt and period = floor(clk_hz / class rate). If total is below period, both counts grow by floor((period - total)/2), and lcnt additionally takes the odd leftover cycle, so that the total then equals period.
- R8: If total is at or above period, the unpadded counts of R5 are output unchanged.
- R9: done_o is high for exactly one cycle per accepted request. hcnt_o, lcnt_o, sda_hold_o and err_o change only in that cycle and hold their values until the next one.
- R10: start_i is accepted only when busy_o is 0. A start in any busy cycle, including the done cycle, leaves the running result and the outputs untouched and starts nothing.
- R11: done_o follows an accepted start within 7*(NUM_W+4)+8 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a calculation; all operand inputs are captured in the accepting cycle |
| clk_hz_i | input | 32 | Controller clock frequency in Hz |
| req_speed_i | input | 32 | Requested bus rate in Hz |
| hs_allow_i | input | 1 | Permits selection of the high-speed class |
| spk_len_i | input | 8 | Spike-suppression length in cycles |
| rise_ns_i | input | 16 | SCL rise time override in ns, 0 = class default |
| fall_ns_i | input | 16 | SCL fall time override in ns, 0 = class default |
| hold_ns_i | input | 16 | SDA hold time override in ns, 0 = 300 ns |
| busy_o | output | 1 | A calculation is in progress (includes the done cycle) |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last result was impossible (negative count) |
| hcnt_o | output | 32 | SCL high count |
| lcnt_o | output | 32 | SCL low count |
| sda_hold_o | output | 32 | SDA hold count |

## Verification
The completion pulse and the acceptance of a new request can fall in the same cycle. The bench provokes this by raising start_i, with different operands, exactly in the cycle it sees done_o high. It judges the outcome by requiring busy_o to be low on the next cycle, no further done pulse, and the outputs held at the first result on every following clock. A second overlap, a start raised in the middle of a running calculation, is judged the same way against the result predicted from the first request's operands.

// File: rtl/sclcalc_pkg.sv
package sclcalc_pkg;
  localparam int CNT_W  = 32;
  localparam int WIDE_W = 40;

  typedef enum logic [1:0] {
    SPD_STD  = 2'd0,
    SPD_FAST = 2'd1,
    SPD_HIGH = 2'd2
  } spd_e;

  typedef struct packed {
    logic             err;
    logic [CNT_W-1:0] hcnt;
    logic [CNT_W-1:0] lcnt;
  } solve_t;

  // Class selection from the requested rate (R2).
  function automatic spd_e pick_mode(input logic [CNT_W-1:0] req,
                                     input logic             hs_ok,
                                     input logic [CNT_W-1:0] fast_rate,
                                     input logic [CNT_W-1:0] hs_rate);
    if (hs_ok && (req >= hs_rate)) return SPD_HIGH;
    if (req >= fast_rate)          return SPD_FAST;
    return SPD_STD;
  endfunction

  // Zero means "keep the default".
  function automatic logic [CNT_W-1:0] pick_ns(input logic [CNT_W-1:0] ovr,
                                               input logic [CNT_W-1:0] dflt);
    return (ovr != '0) ? ovr : dflt;
  endfunction

  // Back-solve the programmable counts and pad to the period (R5..R8).
  function automatic solve_t solve_counts(input logic [CNT_W-1:0] high_c,
                                          input logic [CNT_W-1:0] low_c,
                                          input logic [CNT_W-1:0] rise_c,
                                          input logic [CNT_W-1:0] fall_c,
                                          input logic [CNT_W-1:0] period_c,
                                          input logic [CNT_W-1:0] spk_c);
    logic [WIDE_W-1:0] h, l, tot, gap, half;
    solve_t r;
    gap  = '0;
    half = '0;
    h = WIDE_W'(high_c) - WIDE_W'(fall_c) - WIDE_W'(7) - WIDE_W'(spk_c);
    l = WIDE_W'(low_c) - WIDE_W'(rise_c) + WIDE_W'(fall_c) - WIDE_W'(1);
    r.err = h[WIDE_W-1] | l[WIDE_W-1];
    tot = h + l + WIDE_W'(8) + WIDE_W'(spk_c) + WIDE_W'(rise_c);
    if (!r.err && (tot < WIDE_W'(period_c))) begin
      gap  = WIDE_W'(period_c) - tot;
      half = gap >> 1;
      h    = h + half;
      l    = l + (gap - half);
    end
    r.hcnt = r.err ? '0 : h[CNT_W-1:0];
    r.lcnt = r.err ? '0 : l[CNT_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/sclcalc_div.sv
// Restoring divider: one quotient bit per cycle, NUM_W cycles per division.
module sclcalc_div #(
  parameter int NUM_W = 48,
  parameter int DEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [NUM_W-1:0] quo_o,
  output logic             done_o
);
  localparam int LEFT_W = $clog2(NUM_W + 1);

  logic [DEN_W:0]    rem_q;
  logic [DEN_W-1:0]  den_q;
  logic [NUM_W-1:0]  quo_q;
  logic [LEFT_W-1:0] left_q;
  logic              done_q;
  logic [DEN_W:0]    trial;
  logic              fits;

  always_comb begin
    trial = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};
    fits  = (trial >= {1'b0, den_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      left_q <= '0;
      done_q <= 1'b0;
    end else if (go_i) begin
      rem_q  <= '0;
      den_q  <= den_i;
      quo_q  <= num_i;
      left_q <= LEFT_W'(NUM_W);
      done_q <= 1'b0;
    end else if (left_q != '0) begin
      rem_q  <= fits ? (trial - {1'b0, den_q}) : trial;
      quo_q  <= {quo_q[NUM_W-2:0], fits};
      left_q <= left_q - 1'b1;
      done_q <= (left_q == LEFT_W'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign quo_o  = quo_q;
  assign done_o = done_q;
endmodule

// File: rtl/sclcalc_mode.sv
// Speed class lookup: rate and per-class time constants.
module sclcalc_mode
  import sclcalc_pkg::*;
#(
  parameter int STD_RATE     = 100000,
  parameter int FAST_RATE    = 400000,
  parameter int HS_RATE      = 3400000,
  parameter int STD_HIGH_NS  = 4000,
  parameter int STD_LOW_NS   = 4700,
  parameter int FAST_HIGH_NS = 600,
  parameter int FAST_LOW_NS  = 1300,
  parameter int HS_HIGH_NS   = 60,
  parameter int HS_LOW_NS    = 160,
  parameter int STD_RISE_NS  = 1000,
  parameter int STD_FALL_NS  = 300,
  parameter int FAST_RISE_NS = 300,
  parameter int FAST_FALL_NS = 300,
  parameter int HS_RISE_NS   = 120,
  parameter int HS_FALL_NS   = 120
) (
  input  logic [CNT_W-1:0] req_speed_i,
  input  logic             hs_ok_i,
  output spd_e             mode_o,
  output logic [CNT_W-1:0] rate_o,
  output logic [CNT_W-1:0] rise_def_o,
  output logic [CNT_W-1:0] fall_def_o,
  output logic [CNT_W-1:0] high_min_o,
  output logic [CNT_W-1:0] low_min_o
);
  always_comb begin
    mode_o = pick_mode(req_speed_i, hs_ok_i, CNT_W'(FAST_RATE), CNT_W'(HS_RATE));
    unique case (mode_o)
      SPD_HIGH: begin
        rate_o     = CNT_W'(HS_RATE);
        rise_def_o = CNT_W'(HS_RISE_NS);
        fall_def_o = CNT_W'(HS_FALL_NS);
        high_min_o = CNT_W'(HS_HIGH_NS);
        low_min_o  = CNT_W'(HS_LOW_NS);
      end
      SPD_FAST: begin
        rate_o     = CNT_W'(FAST_RATE);
        rise_def_o = CNT_W'(FAST_RISE_NS);
        fall_def_o = CNT_W'(FAST_FALL_NS);
        high_min_o = CNT_W'(FAST_HIGH_NS);
        low_min_o  = CNT_W'(FAST_LOW_NS);
      end
      default: begin
        rate_o     = CNT_W'(STD_RATE);
        rise_def_o = CNT_W'(STD_RISE_NS);
        fall_def_o = CNT_W'(STD_FALL_NS);
        high_min_o = CNT_W'(STD_HIGH_NS);
        low_min_o  = CNT_W'(STD_LOW_NS);
      end
    endcase
  end
endmodule

// File: rtl/i2c_scl_timing_calc.sv
module i2c_scl_timing_calc
  import sclcalc_pkg::*;
#(
  parameter int NS_W         = 16,
  parameter int SPK_W        = 8,
  parameter int NUM_W        = 48,
  parameter int HOLD_DEF_NS  = 300,
  parameter int STD_RATE     = 100000,
  parameter int FAST_RATE    = 400000,
  parameter int HS_RATE      = 3400000,
  parameter int STD_HIGH_NS  = 4000,
  parameter int STD_LOW_NS   = 4700,
  parameter int FAST_HIGH_NS = 600,
  parameter int FAST_LOW_NS  = 1300,
  parameter int HS_HIGH_NS   = 60,
  parameter int HS_LOW_NS    = 160
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] clk_hz_i,
  input  logic [CNT_W-1:0] req_speed_i,
  input  logic             hs_allow_i,
  input  logic [SPK_W-1:0] spk_len_i,
  input  logic [NS_W-1:0]  rise_ns_i,
  input  logic [NS_W-1:0]  fall_ns_i,
  input  logic [NS_W-1:0]  hold_ns_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [CNT_W-1:0] hcnt_o,
  output logic [CNT_W-1:0] lcnt_o,
  output logic [CNT_W-1:0] sda_hold_o
);
  localparam int N_STEPS = 7;
  localparam int STEP_W  = $clog2(N_STEPS);
  localparam int LAT_MAX = N_STEPS * (NUM_W + 4) + 8;
  // Slot indices: order of the division sequence.
  localparam int I_KCLK = 0;
  localparam int I_PER  = 1;
  localparam int I_RISE = 2;
  localparam int I_FALL = 3;
  localparam int I_HIGH = 4;
  localparam int I_LOW  = 5;
  localparam int I_HOLD = 6;
  localparam logic [CNT_W-1:0] KILO = CNT_W'(1000);
  localparam logic [CNT_W-1:0] MEGA = CNT_W'(1000000);

  typedef enum logic [2:0] {ST_IDLE, ST_LAUNCH, ST_WAIT, ST_SOLVE, ST_DONE} st_e;

  st_e               state_q;
  logic [STEP_W-1:0] step_q;

  // Named internal events (observed by the checker).
  logic accept_w, div_go_w, div_done_w, slot_we_w;

  // Class lookup on live inputs, captured on accept.
  spd_e             mode_w;
  logic [CNT_W-1:0] rate_w, drise_w, dfall_w, mhigh_w, mlow_w;

  sclcalc_mode #(
    .STD_RATE(STD_RATE), .FAST_RATE(FAST_RATE), .HS_RATE(HS_RATE),
    .STD_HIGH_NS(STD_HIGH_NS), .STD_LOW_NS(STD_LOW_NS),
    .FAST_HIGH_NS(FAST_HIGH_NS), .FAST_LOW_NS(FAST_LOW_NS),
    .HS_HIGH_NS(HS_HIGH_NS), .HS_LOW_NS(HS_LOW_NS)
  ) u_mode (
    .req_speed_i(req_speed_i),
    .hs_ok_i    (hs_allow_i),
    .mode_o     (mode_w),
    .rate_o     (rate_w),
    .rise_def_o (drise_w),
    .fall_def_o (dfall_w),
    .high_min_o (mhigh_w),
    .low_min_o  (mlow_w)
  );

  logic [CNT_W-1:0] clk_q, rate_q, spk_q;
  logic [CNT_W-1:0] rise_ns_q, fall_ns_q, high_ns_q, low_ns_q, hold_ns_q;

  assign accept_w = start_i && (state_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q     <= '0;
      rate_q    <= '0;
      spk_q     <= '0;
      rise_ns_q <= '0;
      fall_ns_q <= '0;
      high_ns_q <= '0;
      low_ns_q  <= '0;
      hold_ns_q <= '0;
    end else if (accept_w) begin
      clk_q     <= clk_hz_i;
      rate_q    <= rate_w;
      spk_q     <= CNT_W'(spk_len_i);
      rise_ns_q <= pick_ns(CNT_W'(rise_ns_i), drise_w);
      fall_ns_q <= pick_ns(CNT_W'(fall_ns_i), dfall_w);
      high_ns_q <= mhigh_w;
      low_ns_q  <= mlow_w;
      hold_ns_q <= pick_ns(CNT_W'(hold_ns_i), CNT_W'(HOLD_DEF_NS));
    end
  end

  // Sequencer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:   if (accept_w) begin
                     state_q <= ST_LAUNCH;
                     step_q  <= '0;
                   end
        ST_LAUNCH: state_q <= ST_WAIT;
        ST_WAIT:   if (div_done_w) begin
                     if (step_q == STEP_W'(N_STEPS - 1)) state_q <= ST_SOLVE;
                     else begin
                       step_q  <= step_q + 1'b1;
                       state_q <= ST_LAUNCH;
                     end
                   end
        ST_SOLVE:  state_q <= ST_DONE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  // Divider operands per step.
  logic [CNT_W-1:0] slot_q [N_STEPS];
  logic [CNT_W-1:0] ns_sel;
  logic [NUM_W-1:0] num_w;
  logic [CNT_W-1:0] den_w;
  logic [NUM_W-1:0] quo_w;

  always_comb begin
    unique case (step_q)
      STEP_W'(I_RISE): ns_sel = rise_ns_q;
      STEP_W'(I_FALL): ns_sel = fall_ns_q;
      STEP_W'(I_HIGH): ns_sel = high_ns_q;
      STEP_W'(I_LOW):  ns_sel = low_ns_q;
      default:         ns_sel = hold_ns_q;
    endcase
    if (step_q == STEP_W'(I_KCLK)) begin
      num_w = NUM_W'(clk_q);
      den_w = KILO;
    end else if (step_q == STEP_W'(I_PER)) begin
      num_w = NUM_W'(clk_q);
      den_w = rate_q;
    end else begin
      num_w = NUM_W'(slot_q[I_KCLK]) * NUM_W'(ns_sel) + NUM_W'(MEGA - 1'b1);
      den_w = MEGA;
    end
  end

  assign div_go_w = (state_q == ST_LAUNCH);

  sclcalc_div #(.NUM_W(NUM_W), .DEN_W(CNT_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go_i  (div_go_w),
    .num_i (num_w),
    .den_i (den_w),
    .quo_o (quo_w),
    .done_o(div_done_w)
  );

  assign slot_we_w = (state_q == ST_WAIT) && div_done_w;

  for (genvar g = 0; g < N_STEPS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     slot_q[g] <= '0;
      else if (slot_we_w && (step_q == STEP_W'(g)))   slot_q[g] <= quo_w[CNT_W-1:0];
    end
  end

  // Convenience views of the slots (checker connections).
  logic [CNT_W-1:0] per_c, rise_c, fall_c, high_c, low_c;
  assign per_c  = slot_q[I_PER];
  assign rise_c = slot_q[I_RISE];
  assign fall_c = slot_q[I_FALL];
  assign high_c = slot_q[I_HIGH];
  assign low_c  = slot_q[I_LOW];

  solve_t solve_w;
  assign solve_w = solve_counts(high_c, low_c, rise_c, fall_c, per_c, spk_q);

  logic             err_q;
  logic [CNT_W-1:0] hcnt_q, lcnt_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      hcnt_q <= '0;
      lcnt_q <= '0;
      hold_q <= '0;
    end else if (state_q == ST_SOLVE) begin
      err_q  <= solve_w.err;
      hcnt_q <= solve_w.hcnt;
      lcnt_q <= solve_w.lcnt;
      hold_q <= solve_w.err ? '0 : slot_q[I_HOLD];
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign err_o      = err_q;
  assign hcnt_o     = hcnt_q;
  assign lcnt_o     = lcnt_q;
  assign sda_hold_o = hold_q;
endmodule

// File: rtl/sclcalc_chk.sv
module sclcalc_chk #(
  parameter int CW      = 32,
  parameter int LAT_MAX = 372
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic [CW-1:0] hcnt_o,
  input logic [CW-1:0] lcnt_o,
  input logic [CW-1:0] sda_hold_o,
  input logic          accept_w,
  input logic [CW-1:0] spk_q,
  input logic [CW-1:0] per_c,
  input logic [CW-1:0] rise_c,
  input logic [CW-1:0] fall_c,
  input logic [CW-1:0] high_c,
  input logic [CW-1:0] low_c
);
  logic [15:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lat_q <= '0;
    else if (accept_w) lat_q <= '0;
    else if (busy_o)   lat_q <= lat_q + 1'b1;
  end

  logic [CW+7:0] sum_out, sum_min;
  assign sum_out = (CW+8)'(hcnt_o) + (CW+8)'(lcnt_o) + (CW+8)'(8) + (CW+8)'(spk_q) + (CW+8)'(rise_c);
  assign sum_min = (CW+8)'(high_c) + (CW+8)'(low_c);

  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r9_outputs_move_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(hcnt_o) || !$stable(lcnt_o) || !$stable(sda_hold_o) || !$stable(err_o)) |-> done_o);
  a_r10_no_accept_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !accept_w);
  a_r6_error_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> (hcnt_o == '0 && lcnt_o == '0 && sda_hold_o == '0));
  a_r7_period_met: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o && (sum_min < (CW+8)'(per_c))) |-> (sum_out == (CW+8)'(per_c)));
  a_r8_unpadded_high: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o && (sum_min >= (CW+8)'(per_c)))
      |-> ((CW+8)'(hcnt_o) + (CW+8)'(fall_c) + (CW+8)'(7) + (CW+8)'(spk_q) == (CW+8)'(high_c)));
  a_r11_latency_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (lat_q < 16'(LAT_MAX)));
endmodule

bind i2c_scl_timing_calc sclcalc_chk #(.CW(sclcalc_pkg::CNT_W), .LAT_MAX(LAT_MAX)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .hcnt_o    (hcnt_o),
  .lcnt_o    (lcnt_o),
  .sda_hold_o(sda_hold_o),
  .accept_w  (accept_w),
  .spk_q     (spk_q),
  .per_c     (per_c),
  .rise_c    (rise_c),
  .fall_c    (fall_c),
  .high_c    (high_c),
  .low_c     (low_c)
);

// File: tb/i2c_scl_timing_calc_test.sv
module i2c_scl_timing_calc_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT_LIMIT  = 400;
  localparam int HS_HIGH    = 200;   // raised so that high-speed needs no padding (R8)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] clk_hz_i = '0, req_speed_i = '0;
  logic        hs_allow_i = 1'b0;
  logic [7:0]  spk_len_i = '0;
  logic [15:0] rise_ns_i = '0, fall_ns_i = '0, hold_ns_i = '0;
  logic        busy_o, done_o, err_o;
  logic [31:0] hcnt_o, lcnt_o, sda_hold_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_scl_timing_calc #(.HS_HIGH_NS(HS_HIGH)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .clk_hz_i(clk_hz_i),
    .req_speed_i(req_speed_i), .hs_allow_i(hs_allow_i), .spk_len_i(spk_len_i),
    .rise_ns_i(rise_ns_i), .fall_ns_i(fall_ns_i), .hold_ns_i(hold_ns_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .hcnt_o(hcnt_o), .lcnt_o(lcnt_o), .sda_hold_o(sda_hold_o)
  );

  int     n_chk = 0, n_err = 0;
  int     launches = 0, dones = 0, lat = 0;
  bit     mon_on = 1'b0;
  string  cur_tag = "";
  longint nxt_h, nxt_l, nxt_d, exp_h = 0, exp_l = 0, exp_d = 0;
  bit     nxt_e, exp_e = 1'b0;

  task automatic check(input string tag, input longint act, input longint expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // Reference model written from the requirements.
  function automatic longint to_cnt(input longint hz, input longint ns);
    return ((hz / 1000) * ns + 999999) / 1000000;
  endfunction

  task automatic model(input longint hz, input longint spd, input bit hsok, input longint spk,
                       input longint r_o, input longint f_o, input longint h_o,
                       output longint h, output longint l, output longint d, output bit e);
    longint rate, r_ns, f_ns, hi_ns, lo_ns, per, rc, fc, tot, diff;
    if (hsok && spd >= 3400000) begin rate = 3400000; r_ns = 120;  f_ns = 120; hi_ns = HS_HIGH; lo_ns = 160;  end
    else if (spd >= 400000)     begin rate = 400000;  r_ns = 300;  f_ns = 300; hi_ns = 600;     lo_ns = 1300; end
    else                        begin rate = 100000;  r_ns = 1000; f_ns = 300; hi_ns = 4000;    lo_ns = 4700; end
    if (r_o != 0) r_ns = r_o;
    if (f_o != 0) f_ns = f_o;
    per = hz / rate;
    rc = to_cnt(hz, r_ns);
    fc = to_cnt(hz, f_ns);
    h = to_cnt(hz, hi_ns) - fc - 7 - spk;
    l = to_cnt(hz, lo_ns) - rc + fc - 1;
    d = to_cnt(hz, (h_o != 0) ? h_o : 300);
    e = (h < 0) || (l < 0);
    if (e) begin h = 0; l = 0; d = 0; end
    else begin
      tot = h + l + 7 + spk + rc + 1;
      if (tot < per) begin
        diff = (per - tot) / 2;
        h += diff; l += diff;
        tot = h + l + 7 + spk + rc + 1;
        l += per - tot;
      end
    end
  endtask

  task automatic set_in(input longint hz, input longint spd, input bit hsok, input int spk,
                        input int r_o, input int f_o, input int h_o);
    clk_hz_i = 32'(hz); req_speed_i = 32'(spd); hs_allow_i = hsok; spk_len_i = 8'(spk);
    rise_ns_i = 16'(r_o); fall_ns_i = 16'(f_o); hold_ns_i = 16'(h_o);
  endtask

  task automatic launch(input string tag, input longint hz, input longint spd, input bit hsok,
                        input int spk, input int r_o, input int f_o, input int h_o);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    set_in(hz, spd, hsok, spk, r_o, f_o, h_o);
    model(hz, spd, hsok, spk, r_o, f_o, h_o, nxt_h, nxt_l, nxt_d, nxt_e);
    cur_tag = tag;
    start_i = 1'b1;
    launches++;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_case(input string tag, input longint hz, input longint spd, input bit hsok,
                          input int spk, input int r_o, input int f_o, input int h_o);
    launch(tag, hz, spd, hsok, spk, r_o, f_o, h_o);
    wait (dones == launches);
    repeat (3) @(negedge clk);
  endtask

  // Per-clock comparison against the model.
  always @(negedge clk) begin
    if (mon_on) begin
      if (launches != dones) begin
        lat++;
        if (lat > LAT_LIMIT) begin
          check("R11 latency bound", lat, LAT_LIMIT);
          dones = launches;
        end
      end
      if (done_o) begin
        if (launches == dones) check("R9/R10 done without accepted request", 1, 0);
        else begin
          check({cur_tag, " R5 hcnt"}, longint'(hcnt_o), nxt_h);
          check({cur_tag, " R5 lcnt"}, longint'(lcnt_o), nxt_l);
          check({cur_tag, " R4 sda hold"}, longint'(sda_hold_o), nxt_d);
          check({cur_tag, " R6 err"}, longint'(err_o), longint'(nxt_e));
          check("R11 latency bound", (lat <= LAT_LIMIT) ? 1 : 0, 1);
          exp_h = nxt_h; exp_l = nxt_l; exp_d = nxt_d; exp_e = nxt_e;
          lat = 0;
          dones = launches;
        end
      end else if (launches == dones) begin
        check("R9 hcnt held", longint'(hcnt_o), exp_h);
        check("R9 lcnt held", longint'(lcnt_o), exp_l);
        check("R9 hold held", longint'(sda_hold_o), exp_d);
        check("R9 err held", longint'(err_o), longint'(exp_e));
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check("watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check("R1 busy after reset", busy_o, 0);
    check("R1 done after reset", done_o, 0);
    check("R1 err after reset", err_o, 0);
    check("R1 hcnt after reset", hcnt_o, 0);
    check("R1 lcnt after reset", lcnt_o, 0);
    check("R1 hold after reset", sda_hold_o, 0);
    rst_n = 1'b1;
    mon_on = 1'b1;

    run_case("R3/R7 standard defaults",      100000000, 100000,  1'b0, 0, 0,   0,  0);
    run_case("R2/R7 fast spk",               50000000,  400000,  1'b0, 3, 0,   0,  0);
    run_case("R3/R4 overrides odd remainder", 133333333, 400000, 1'b0, 1, 120, 80, 500);
    run_case("R2 hs not allowed",            100000000, 3400000, 1'b0, 0, 0,   0,  0);
    run_case("R2/R8 high-speed no padding",  100000000, 3400000, 1'b1, 0, 0,   0,  0);
    run_case("R6 negative count",            1000000,   100000,  1'b0, 0, 0,   0,  0);
    run_case("R6 recovery after error",      24000000,  99999,   1'b0, 2, 0,   0,  0);
    run_case("R2 between rates",             48000000,  1000000, 1'b1, 4, 0,   250, 0);
    run_case("R7 odd shortfall",             12345678,  100000,  1'b0, 1, 0,   0,  0);

    // R10: start in the middle of a running calculation is ignored.
    launch("R10 mid-busy start", 66000000, 400000, 1'b0, 2, 0, 0, 0);
    repeat (20) @(negedge clk);
    set_in(10000000, 100000, 1'b0, 0, 0, 0, 0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R10 still busy after ignored start", busy_o, 1);
    wait (dones == launches);
    repeat (30) @(negedge clk);

    // R10: start in the done cycle is ignored.
    launch("R10 done-cycle start", 80000000, 100000, 1'b0, 0, 0, 0, 400);
    @(negedge clk);
    while (!done_o) @(negedge clk);
    set_in(20000000, 400000, 1'b0, 0, 0, 0, 0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R10 idle after done-cycle start", busy_o, 0);
    repeat (LAT_LIMIT + 20) @(negedge clk);
    check("R10 no second done pulse", dones, launches);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule